// File: doc/BRIEF.md
# Serial Debug Command Slave Interface

This block is the target end of a two-wire programming and debug port. An external host owns a serial clock and a data line. Every rising edge of that clock moves one bit. Each transaction starts with a short command code. The code either pulls in a full instruction word and issues it to the execution side, or sends the contents of a visibility register back to the host. All other code values are reserved. They are absorbed with no effect, and the port is ready for the next code straight away.

The serial clock is the only clock. It drives both the shift logic and the instruction issue, and no internal oscillator takes part. Instructions reach the execution side only through the serial shift buffer, never from memory. The execution side writes into the visibility register through a parallel load port. The host reads that register through the readout command. A mode-enable input keeps the port idle while it is low and clears any transfer in progress.

Top module: `sdc_port`

## Requirements
- R1: While `prog_en` is low, `sdo_oe`, `sdo`, `insn_valid`, `insn_word` and the visibility register are all zero. The first command after `prog_en` rises starts with a fresh command code.
- R2: A command code is 4 bits wide and is sampled from `sdi` on four consecutive rising edges of `sclk`, least significant bit first.
- R3: Code value 0 selects instruction issue. The next 24 `sdi` bits, least significant first, form the instruction. After the edge that samples the last bit, `insn_word` holds the full word and `insn_valid` is high for exactly one `sclk` cycle.
- R4: Code value 1 selects readout. From the edge that samples the last code bit, `sdo_oe` is high and `sdo` shows visibility bit 0. Each later rising edge moves `sdo` to the next higher bit, so 16 bits go out in total. No instruction is issued during a readout.
- R5: The rising edge after bit 15 has been presented releases `sdo_oe`. The edge after that is taken as bit 0 of a new command code.
- R6: Codes 2 through 15 are reserved. They raise neither `insn_valid` nor `sdo_oe`, they leave `insn_word` unchanged, and the next `sdi` bit is bit 0 of a new command code.
- R7: `vis_load` high at a rising edge copies `vis_din` into the visibility register. A readout sends the value held just before the edge that completes its code. A load on that edge, or on any edge during the readout, only affects later readouts.
- R8: When `prog_en` falls partway through a transfer, `sdo_oe` drops at once and the partial code, instruction or readout is discarded. It is never completed or issued.
- R9: `sdi` is ignored while a readout is in progress. Bit patterns sent during a readout start no command.
- R10: `insn_word` changes only on the edge that raises `insn_valid`, and holds its value between issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Host serial clock. It is the shift clock and the execution clock. |
| prog_en | input | 1 | Mode enable, active high. Low holds the port in reset. |
| sdi | input | 1 | Serial data from the host, sampled on rising `sclk` edges. |
| vis_load | input | 1 | Loads `vis_din` into the visibility register. |
| vis_din | input | 16 | Parallel value written by the execution side. |
| sdo | output | 1 | Serial readout data, valid while `sdo_oe` is high. |
| sdo_oe | output | 1 | Output enable for the shared data line. |
| insn_word | output | 24 | Instruction register handed to the execution side. |
| insn_valid | output | 1 | One-cycle issue strobe for `insn_word`. |

## Verification
A bit counter or state that has drifted by even one position shows up at the ports within one command. It appears as `insn_valid` rising early or late, a shifted `insn_word`, or `sdo_oe` opening and closing on the wrong edge. A wrong decode of a reserved or readout code shows on the first transaction that follows. A code bit may then be consumed as payload, or payload taken as a code, and either gives a missing issue or an unexpected output enable. A stale or late visibility snapshot shows in the very first bit that `sdo` presents.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    ST_CODE = 2'd0,
    ST_INSN = 2'd1,
    ST_READ = 2'd2
  } sdc_state_e;

  typedef enum logic [1:0] {
    K_EXEC = 2'd0,
    K_READ = 2'd1,
    K_RSVD = 2'd2
  } sdc_kind_e;

  localparam int unsigned OP_EXEC = 0;
  localparam int unsigned OP_READ = 1;

  // Map a received command code to its action.
  function automatic sdc_kind_e classify(input logic [31:0] code);
    if (code == 32'(OP_EXEC))      return K_EXEC;
    else if (code == 32'(OP_READ)) return K_READ;
    else                           return K_RSVD;
  endfunction

  // Number of bit periods a phase lasts.
  function automatic int unsigned phase_len(input sdc_state_e st,
                                            input int unsigned cw,
                                            input int unsigned iw,
                                            input int unsigned vw);
    case (st)
      ST_INSN: return iw;
      ST_READ: return vw;
      default: return cw;
    endcase
  endfunction

endpackage

// File: rtl/sdc_shift_in.sv
module sdc_shift_in #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  generate
    if (W == 1) begin : g_one
      assign nxt = din;
    end else begin : g_many
      assign nxt = {din, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned INSN_W = 24,
  parameter int unsigned VIS_W  = 16,
  localparam int unsigned MAXLEN = (INSN_W > VIS_W) ?
                                   ((INSN_W > CODE_W) ? INSN_W : CODE_W) :
                                   ((VIS_W > CODE_W) ? VIS_W : CODE_W),
  localparam int unsigned CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_nxt,
  output sdc_state_e        state,
  output logic [CNT_W-1:0]  cnt,
  output logic              code_done,
  output logic              insn_done,
  output logic              read_done,
  output logic              shift_code,
  output logic              shift_insn,
  output logic              shift_read,
  output logic              snap
);
  sdc_kind_e        kind;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  assign kind     = classify(32'(code_nxt));
  assign last_idx = CNT_W'(phase_len(state, CODE_W, INSN_W, VIS_W) - 1);
  assign at_last  = (cnt == last_idx);

  assign shift_code = (state == ST_CODE);
  assign shift_insn = (state == ST_INSN);
  assign shift_read = (state == ST_READ);
  assign code_done  = shift_code && at_last;
  assign insn_done  = shift_insn && at_last;
  assign read_done  = shift_read && at_last;
  assign snap       = code_done && (kind == K_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CODE;
      cnt   <= '0;
    end else if (at_last) begin
      cnt <= '0;
      if (code_done) begin
        case (kind)
          K_EXEC:  state <= ST_INSN;
          K_READ:  state <= ST_READ;
          default: state <= ST_CODE;
        endcase
      end else begin
        state <= ST_CODE;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the bit counter never passes the end of the current phase
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

  // R6: a reserved code returns straight to code collection
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_done && kind == K_RSVD) |=> (state == ST_CODE && cnt == '0));
endmodule

// File: rtl/sdc_vis_out.sv
module sdc_vis_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         snap,
  input  logic         shift,
  output logic         bit0
);
  logic [W-1:0] vis_q;
  logic [W-1:0] out_sr;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vis_q <= '0;
    else if (load) vis_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_sr <= '0;
    else if (snap)  out_sr <= vis_q;
    else if (shift) out_sr <= out_sr >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign bit0 = out_sr[0];

  // R7: the first readout bit is the register value from before the snapshot edge
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(snap) |-> (bit0 == $past(vis_q[0])));
endmodule

// File: rtl/sdc_port.sv
module sdc_port
  import sdc_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned INSN_W = 24,
  parameter int unsigned VIS_W  = 16
) (
  input  logic              sclk,
  input  logic              prog_en,
  input  logic              sdi,
  input  logic              vis_load,
  input  logic [VIS_W-1:0]  vis_din,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [INSN_W-1:0] insn_word,
  output logic              insn_valid
);
  localparam int unsigned MAXLEN = (INSN_W > VIS_W) ?
                                   ((INSN_W > CODE_W) ? INSN_W : CODE_W) :
                                   ((VIS_W > CODE_W) ? VIS_W : CODE_W);
  localparam int unsigned CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  sdc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              code_done, insn_done, read_done;
  logic              shift_code, shift_insn, shift_read, snap;
  logic [CODE_W-1:0] code_nxt;
  logic [INSN_W-1:0] insn_nxt;
  logic              vis_bit;
  logic              armed;

  sdc_shift_in #(.W(CODE_W)) u_code_sr (
    .clk(sclk), .rst_n(prog_en), .en(shift_code), .din(sdi), .nxt(code_nxt)
  );

  sdc_shift_in #(.W(INSN_W)) u_insn_sr (
    .clk(sclk), .rst_n(prog_en), .en(shift_insn), .din(sdi), .nxt(insn_nxt)
  );

  sdc_ctrl #(.CODE_W(CODE_W), .INSN_W(INSN_W), .VIS_W(VIS_W)) u_ctrl (
    .clk(sclk), .rst_n(prog_en), .code_nxt(code_nxt), .state(state), .cnt(cnt),
    .code_done(code_done), .insn_done(insn_done), .read_done(read_done),
    .shift_code(shift_code), .shift_insn(shift_insn), .shift_read(shift_read),
    .snap(snap)
  );

  sdc_vis_out #(.W(VIS_W)) u_vis (
    .clk(sclk), .rst_n(prog_en), .load(vis_load), .din(vis_din),
    .snap(snap), .shift(shift_read), .bit0(vis_bit)
  );

  always_ff @(posedge sclk or negedge prog_en) begin
    if (!prog_en) begin
      insn_word  <= '0;
      insn_valid <= 1'b0;
    end else begin
      insn_valid <= insn_done;
      if (insn_done) insn_word <= insn_nxt;
    end
  end

  always_ff @(posedge sclk or negedge prog_en) begin
    if (!prog_en) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  assign sdo_oe = shift_read;
  assign sdo    = sdo_oe & vis_bit;

  // R3: the issue strobe lasts a single cycle
  p_valid_pulse_r3: assert property (@(posedge sclk) disable iff (!prog_en)
    insn_valid |=> !insn_valid);

  // R4: no instruction issue while the data line is driven
  p_oe_no_issue_r4: assert property (@(posedge sclk) disable iff (!prog_en)
    sdo_oe |-> !insn_valid);

  // R5: output enable is released only by the final readout bit
  p_oe_release_r5: assert property (@(posedge sclk) disable iff (!prog_en || !armed)
    $fell(sdo_oe) |-> $past(read_done));

  // R10: the instruction register holds between issues
  p_word_stable_r10: assert property (@(posedge sclk) disable iff (!prog_en || !armed)
    !insn_valid |-> $stable(insn_word));

  // R2: code collection and payload phases never overlap
  p_phase_excl_r2: assert property (@(posedge sclk) disable iff (!prog_en)
    $countones({shift_code, shift_insn, shift_read}) == 1);
endmodule

// File: tb/sdc_port_bench.sv
module sdc_port_bench;
  logic        clk = 1'b0;
  logic        sclk, prog_en, sdi, vis_load;
  logic [15:0] vis_din;
  logic        sdo, sdo_oe, insn_valid;
  logic [23:0] insn_word;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz base; sclk derived at 5 MHz

  sdc_port u_sdc_port (
    .sclk(sclk), .prog_en(prog_en), .sdi(sdi), .vis_load(vis_load),
    .vis_din(vis_din), .sdo(sdo), .sdo_oe(sdo_oe),
    .insn_word(insn_word), .insn_valid(insn_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One sclk period of 200 ns; returns with sclk low, 100 ns after the rise.
  task automatic tick(input logic b);
    sdi = b;
    repeat (5) @(posedge clk);
    sclk = 1'b1;
    repeat (5) @(posedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_code(input logic [3:0] c);
    for (int i = 0; i < 4; i++) tick(c[i]);
  endtask

  task automatic t_reset;
    chk("R1 oe", {31'd0, sdo_oe}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
    chk("R1 valid", {31'd0, insn_valid}, 32'd0);
    chk("R1 word", {8'd0, insn_word}, 32'd0);
  endtask

  task automatic t_exec(input logic [23:0] w);
    send_code(4'b0000);
    for (int i = 0; i < 23; i++) tick(w[i]);
    chk("R3 no early valid", {31'd0, insn_valid}, 32'd0);
    tick(w[23]);
    chk("R3 valid", {31'd0, insn_valid}, 32'd1);
    chk("R3 word", {8'd0, insn_word}, {8'd0, w});
    chk("R4 oe low in exec", {31'd0, sdo_oe}, 32'd0);
  endtask

  // Readout of 16 bits; sdi held at 0 so a mis-decode would start an exec (R9).
  task automatic t_read(input logic [15:0] exp, input string req);
    send_code(4'b0001);
    for (int i = 0; i < 16; i++) begin
      chk({req, " oe"}, {31'd0, sdo_oe}, 32'd1);
      chk({req, " bit"}, {31'd0, sdo}, {31'd0, exp[i]});
      chk("R4 no issue", {31'd0, insn_valid}, 32'd0);
      tick(1'b0);
    end
    chk("R5 oe released", {31'd0, sdo_oe}, 32'd0);
  endtask

  task automatic t_reserved(input logic [3:0] c, input logic [23:0] held);
    tick(c[0]);
    chk("R3 pulse ends", {31'd0, insn_valid}, 32'd0);
    for (int i = 1; i < 4; i++) tick(c[i]);
    chk("R6 no oe", {31'd0, sdo_oe}, 32'd0);
    chk("R6 no issue", {31'd0, insn_valid}, 32'd0);
    chk("R6 word kept", {8'd0, insn_word}, {8'd0, held});
  endtask

  task automatic t_vis_timing;
    // code 0001: load A on first code edge, B on the completing edge
    vis_din = 16'hA5C3; vis_load = 1'b1; tick(1'b1); vis_load = 1'b0;
    tick(1'b0); tick(1'b0);
    vis_din = 16'h1234; vis_load = 1'b1; tick(1'b0); vis_load = 1'b0;
    for (int i = 0; i < 16; i++) begin
      chk("R7 snapshot bit", {31'd0, sdo}, {31'd0, 1'b0 ^ ((16'hA5C3 >> i) & 16'h1) != 0});
      if (i == 5) begin
        vis_din = 16'h0F0F; vis_load = 1'b1; tick(1'b1); vis_load = 1'b0;
      end else begin
        tick(1'b1);  // all-ones on sdi during readout must be ignored (R9)
      end
    end
    chk("R5 oe released", {31'd0, sdo_oe}, 32'd0);
    t_read(16'h0F0F, "R7 later load");
  endtask

  task automatic t_mode_drop;
    send_code(4'b0000);
    for (int i = 0; i < 10; i++) tick(1'b1);
    prog_en = 1'b0; #1;
    chk("R8 word cleared", {8'd0, insn_word}, 32'd0);
    chk("R8 no issue", {31'd0, insn_valid}, 32'd0);
    repeat (5) @(posedge clk);
    prog_en = 1'b1;
    t_exec(24'h3C_96A1);
    vis_din = 16'hBEEF; vis_load = 1'b1;
    send_code(4'b0001);
    vis_load = 1'b0;
    tick(1'b0); tick(1'b0);
    chk("R8 oe before drop", {31'd0, sdo_oe}, 32'd1);
    prog_en = 1'b0; #1;
    chk("R8 oe drops at once", {31'd0, sdo_oe}, 32'd0);
    chk("R1 sdo off", {31'd0, sdo}, 32'd0);
    repeat (5) @(posedge clk);
    prog_en = 1'b1;
    t_read(16'h0000, "R1 vis cleared");
  endtask

  initial begin
    sclk = 1'b0; prog_en = 1'b0; sdi = 1'b0; vis_load = 1'b0; vis_din = '0;
    repeat (4) @(posedge clk);
    t_reset;
    prog_en = 1'b1;
    repeat (4) @(posedge clk);
    t_exec(24'hA5_0F33);
    t_reserved(4'b0010, 24'hA5_0F33);
    t_exec(24'h80_0001);
    t_reserved(4'b1111, 24'h80_0001);
    t_read(16'h0000, "R4 empty");
    t_exec(24'h7F_FFFE);  // R9: exec decoded right after a readout
    t_reserved(4'b1000, 24'h7F_FFFE);
    t_vis_timing;
    t_exec(24'h12_3456);
    t_mode_drop;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule